// File: doc/BRIEF.md
# Strobe-framed serial register slave

This block is the device side of a four-wire serial register port. The wires are a serial clock, a data line into the device, a data line out of it, and an active-low strobe. The host drives the clock and the data-in line. The block samples data-in on each rising serial clock and keeps a running history of the bits it has received.

No chip select frames a transfer. Instead, one rising clock edge taken while the strobe is low commits a command. The data-in level on that edge gives the direction.

- For a write, the host first shifts in the data word and then the address. The strobed clock then copies the history into the addressed register.
- For a read, the host shifts in the address only. The strobed clock loads the addressed register into an output shifter. Falling serial clocks then drive that word onto data-out, most significant bit first, during the next data-width clocks.

The register file has these entries:

- a read/write mode word;
- a read/write mux word;
- read-only switch inputs, taken through a synchroniser;
- a read-only version constant;
- a reset-control entry. Writing 1 to it raises a reset request for a set number of system clocks. After that it clears itself.

The serial clock, the strobe and data-in all pass through the same synchroniser. Because they share one path, they stay aligned inside the system clock domain.

Top module: `strb_serial_regs`

## Requirements
- R1: After reset, `mode_word` equals MODE_RST and `mux_word` equals MUX_RST, both defaulting to 0. `ser_dout` is 1 and `reset_req` is 0.
- R2: A write is framed as follows, every field most significant bit first: DATA_W data bits, then ADDR_W address bits, then one rising clock with `ser_stb_n` low and `ser_din` at 1. After that frame, the register at A_MODE (default 0x00) or A_MUX (default 0x02) holds the data. Its value appears on `mode_word` or `mux_word`.
- R3: A read is framed as ADDR_W address bits, then one rising clock with `ser_stb_n` low and `ser_din` at 0. After that, `ser_dout` presents the addressed word most significant bit first. It changes only after falling serial clocks. The first bit is valid after the falling edge of the strobed clock.
- R4: `ser_dout` is 1 outside the data phase of a read. This covers the time after the last read bit and the time after a write.
- R5: A write to A_SW (default 0x08), to A_VER (default 0xFF) or to any unmapped address changes no register.
- R6: A read returns the following values:
  - A_VER returns VERSION.
  - A_SW returns the synchronised `sw_in`, zero-extended.
  - A_RST (default 0x80) returns 1 while a reset request is active and 0 otherwise.
  - An unmapped address returns 0.
- R7: A write of exactly 1 to A_RST holds `reset_req` high for RST_PULSE_CYC system clocks. The entry then reads 0 again. A write of any other value to A_RST leaves `reset_req` low.
- R8: Rising serial clocks with `ser_stb_n` high change no register. A later strobed write clock commits the most recent DATA_W+ADDR_W bits received.
- R9: A port change reaches the block's state SYNC_STAGES+1 system clocks after the serial input changes. This applies to register updates, `ser_dout` updates and the start of `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_stb_n | input | 1 | Active-low command strobe |
| ser_dout | output | 1 | Serial data to the host, idles high |
| sw_in | input | SW_W | Switch levels, asynchronous |
| mode_word | output | DATA_W | Mode register contents |
| mux_word | output | DATA_W | Mux register contents |
| reset_req | output | 1 | System reset request pulse |

## Verification
The bench uses the default 32-bit data, 8-bit address and two-stage synchroniser, so the full frame timing is exercised. It shortens the reset pulse to 5 clocks, so the bench can count the whole pulse and still read the reset-control entry back after it has cleared. The switch width is set to 8 so that the zero-extension of a read is visible. A behavioural model delays the inputs through a queue of SYNC_STAGES entries. It is compared with the outputs on every clock, which pins down the latency in R9 exactly.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("ssr_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else if (i == 0) st[i] <= d;
            else st[i] <= st[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/ssr_frontend.sv
module ssr_frontend
   import ssr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              stb_n_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cmd_valid,
   output dir_e              cmd_dir,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic              sdo
);
   localparam int HIST_W = DATA_W + ADDR_W;

   logic              sclk_d;
   logic              rise, fall;
   logic [HIST_W-1:0] hist;
   logic [DATA_W-1:0] out_sr;

   assign rise      = sclk_s & ~sclk_d;
   assign fall      = ~sclk_s & sclk_d;
   assign cmd_valid = rise & ~stb_n_s;
   assign cmd_dir   = dir_e'(sdi_s);
   assign cmd_addr  = hist[ADDR_W-1:0];
   assign cmd_data  = hist[ADDR_W +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         hist   <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (rise && stb_n_s) hist <= {hist[HIST_W-2:0], sdi_s};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sr <= '1;
         sdo    <= 1'b1;
      end else if (cmd_valid && cmd_dir == DIR_RD) begin
         out_sr <= rd_data;
      end else if (fall) begin
         sdo    <= out_sr[DATA_W-1];
         out_sr <= {out_sr[DATA_W-2:0], 1'b1};
      end
   end

   // R3: data-out moves only after a synchronised falling serial clock
   a_r3_sdo_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(sdo));
endmodule

// File: rtl/ssr_regfile.sv
module ssr_regfile
   import ssr_pkg::*;
#(
   parameter int              DATA_W        = 32,
   parameter int              ADDR_W        = 8,
   parameter int              SW_W          = 8,
   parameter int              A_MODE        = 'h00,
   parameter int              A_MUX         = 'h02,
   parameter int              A_SW          = 'h08,
   parameter int              A_RST         = 'h80,
   parameter int              A_VER         = 'hFF,
   parameter logic [DATA_W-1:0] MODE_RST    = '0,
   parameter logic [DATA_W-1:0] MUX_RST     = '0,
   parameter logic [DATA_W-1:0] VERSION     = 'h0001_0000,
   parameter int              RST_PULSE_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  dir_e              cmd_dir,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [SW_W-1:0]   sw_s,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] mux_q,
   output logic              rst_req
);
   localparam int CNT_W = $clog2(RST_PULSE_CYC + 1);
   localparam logic [ADDR_W-1:0] AM = ADDR_W'(A_MODE);
   localparam logic [ADDR_W-1:0] AX = ADDR_W'(A_MUX);
   localparam logic [ADDR_W-1:0] AS = ADDR_W'(A_SW);
   localparam logic [ADDR_W-1:0] AR = ADDR_W'(A_RST);
   localparam logic [ADDR_W-1:0] AV = ADDR_W'(A_VER);

   generate
      if (RST_PULSE_CYC < 1) begin : g_bad_pulse
         $error("ssr_regfile: RST_PULSE_CYC must be at least 1");
      end
      if (SW_W > DATA_W) begin : g_bad_sw
         $error("ssr_regfile: SW_W exceeds DATA_W");
      end
      if (A_MODE == A_MUX || A_MODE == A_SW || A_MODE == A_RST || A_MODE == A_VER ||
          A_MUX == A_SW || A_MUX == A_RST || A_MUX == A_VER ||
          A_SW == A_RST || A_SW == A_VER || A_RST == A_VER) begin : g_bad_map
         $error("ssr_regfile: register addresses must be distinct");
      end
      if (A_MODE >= (1 << ADDR_W) || A_MUX >= (1 << ADDR_W) || A_SW >= (1 << ADDR_W) ||
          A_RST >= (1 << ADDR_W) || A_VER >= (1 << ADDR_W)) begin : g_bad_range
         $error("ssr_regfile: address does not fit ADDR_W");
      end
   endgenerate

   logic             wr;
   logic             we_mode, we_mux, start;
   logic [CNT_W-1:0] cnt;

   assign wr      = cmd_valid && cmd_dir == DIR_WR;
   assign we_mode = wr && cmd_addr == AM;
   assign we_mux  = wr && cmd_addr == AX;
   assign start   = wr && cmd_addr == AR && cmd_data == DATA_W'(1);
   assign rst_req = cnt != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         mux_q  <= MUX_RST;
      end else begin
         if (we_mode) mode_q <= cmd_data;
         if (we_mux)  mux_q  <= cmd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (start)   cnt <= CNT_W'(RST_PULSE_CYC);
      else if (rst_req) cnt <= cnt - 1'b1;
   end

   always_comb begin
      rd_data = '0;
      if (cmd_addr == AM)      rd_data = mode_q;
      else if (cmd_addr == AX) rd_data = mux_q;
      else if (cmd_addr == AS) rd_data = DATA_W'(sw_s);
      else if (cmd_addr == AR) rd_data = DATA_W'(rst_req);
      else if (cmd_addr == AV) rd_data = VERSION;
   end

   // R7: a reset request begins only after a committed write of 1
   a_r7_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(cmd_valid && cmd_dir == DIR_WR && cmd_data == DATA_W'(1)));

   // R5: writes outside the writable words leave both words untouched
   a_r5_ro_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_dir == DIR_WR && cmd_addr != AM && cmd_addr != AX)
      |=> ($stable(mode_q) && $stable(mux_q)));

   // R8: the mode word changes only after a strobed write command
   a_r8_mode_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> $past(cmd_valid && cmd_dir == DIR_WR));
endmodule

// File: rtl/strb_serial_regs.sv
module strb_serial_regs
   import ssr_pkg::*;
#(
   parameter int                DATA_W        = 32,
   parameter int                ADDR_W        = 8,
   parameter int                SW_W          = 8,
   parameter int                SYNC_STAGES   = 2,
   parameter int                A_MODE        = 'h00,
   parameter int                A_MUX         = 'h02,
   parameter int                A_SW          = 'h08,
   parameter int                A_RST         = 'h80,
   parameter int                A_VER         = 'hFF,
   parameter logic [DATA_W-1:0] MODE_RST      = '0,
   parameter logic [DATA_W-1:0] MUX_RST       = '0,
   parameter logic [DATA_W-1:0] VERSION       = 'h0001_0000,
   parameter int                RST_PULSE_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              ser_stb_n,
   output logic              ser_dout,
   input  logic [SW_W-1:0]   sw_in,
   output logic [DATA_W-1:0] mode_word,
   output logic [DATA_W-1:0] mux_word,
   output logic              reset_req
);
   generate
      if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_w
         $error("strb_serial_regs: DATA_W must be >= 2 and ADDR_W >= 1");
      end
   endgenerate

   logic [2:0]        ser_s;
   logic [SW_W-1:0]   sw_s;
   logic              cmd_valid;
   dir_e              cmd_dir;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;
   logic [DATA_W-1:0] rd_data;

   ssr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_ser_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_stb_n, ser_clk, ser_din}), .q(ser_s)
   );

   ssr_sync #(.W(SW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sw_sync (
      .clk(clk), .rst_n(rst_n), .d(sw_in), .q(sw_s)
   );

   ssr_frontend #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_front (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(ser_s[1]), .sdi_s(ser_s[0]), .stb_n_s(ser_s[2]),
      .rd_data(rd_data),
      .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .sdo(ser_dout)
   );

   ssr_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SW_W(SW_W),
      .A_MODE(A_MODE), .A_MUX(A_MUX), .A_SW(A_SW), .A_RST(A_RST), .A_VER(A_VER),
      .MODE_RST(MODE_RST), .MUX_RST(MUX_RST), .VERSION(VERSION),
      .RST_PULSE_CYC(RST_PULSE_CYC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .sw_s(sw_s),
      .rd_data(rd_data), .mode_q(mode_word), .mux_q(mux_word), .rst_req(reset_req)
   );
endmodule

// File: tb/strb_serial_regs_tb.sv
module strb_serial_regs_tb;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int SWW = 8;
   localparam int SYNC = 2;
   localparam int PULSE = 5;
   localparam int HOLD = 6;
   localparam logic [DW-1:0] VER = 32'hA5C3_0107;
   localparam logic [SWW-1:0] SWV = 8'hB6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_din = 1'b0, ser_stb_n = 1'b1;
   logic ser_dout, reset_req;
   logic [SWW-1:0] sw_in = SWV;
   logic [DW-1:0] mode_word, mux_word;

   int total = 0, bad = 0, req_hi = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   strb_serial_regs #(.DATA_W(DW), .ADDR_W(AW), .SW_W(SWW), .SYNC_STAGES(SYNC),
      .VERSION(VER), .RST_PULSE_CYC(PULSE)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_stb_n(ser_stb_n), .ser_dout(ser_dout), .sw_in(sw_in),
      .mode_word(mode_word), .mux_word(mux_word), .reset_req(reset_req)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural reference, inputs delayed by a queue of SYNC entries
   logic [2:0]     q[$];
   logic [DW+AW-1:0] m_hist;
   logic [DW-1:0]  m_mode, m_mux, m_osr;
   logic           m_sdo, m_prev;
   int             m_cnt;

   function automatic logic [DW-1:0] m_read(logic [AW-1:0] a, bit act);
      case (a)
         8'h00: return m_mode;
         8'h02: return m_mux;
         8'h08: return DW'(SWV);
         8'h80: return DW'(act);
         8'hFF: return VER;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_hist = '0; m_mode = '0; m_mux = '0; m_osr = '1;
         m_sdo = 1'b1; m_prev = 1'b0; m_cnt = 0;
      end else begin
         q.push_back({ser_stb_n, ser_clk, ser_din});
         if (q.size() > SYNC) begin
            logic [2:0] s;
            bit act;
            s = q.pop_front();
            act = (m_cnt != 0);
            if (m_cnt > 0) m_cnt--;
            if (s[1] && !m_prev) begin
               if (!s[2]) begin
                  logic [AW-1:0] a;
                  logic [DW-1:0] d;
                  a = m_hist[AW-1:0];
                  d = m_hist[DW+AW-1:AW];
                  if (s[0]) begin
                     if (a == 8'h00) m_mode = d;
                     if (a == 8'h02) m_mux = d;
                     if (a == 8'h80 && d == 1) m_cnt = PULSE;
                  end else begin
                     m_osr = m_read(a, act);
                  end
               end else begin
                  m_hist = {m_hist[DW+AW-2:0], s[0]};
               end
            end else if (!s[1] && m_prev) begin
               m_sdo = m_osr[DW-1];
               m_osr = {m_osr[DW-2:0], 1'b1};
            end
            m_prev = s[1];
         end
      end
   end

   // every-clock comparison against the model (R9 latency, R2 R3 R4 R7)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R9 mode_word", mode_word, m_mode);
         check("R9 mux_word", mux_word, m_mux);
         check("R9 ser_dout", DW'(ser_dout), DW'(m_sdo));
         check("R9 reset_req", DW'(reset_req), DW'(m_cnt != 0));
         if (reset_req) req_hi++;
      end
   end

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(bit b, bit strobe);
      ser_din = b;
      if (strobe) ser_stb_n = 1'b0;
      wt(HOLD); ser_clk = 1'b1;
      wt(HOLD); ser_clk = 1'b0;
      wt(HOLD); ser_stb_n = 1'b1;
   endtask

   task automatic send_bits(logic [DW-1:0] v, int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i], 1'b0);
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
      send_bits(d, DW);
      send_bits(DW'(a), AW);
      send_bit(1'b1, 1'b1);
   endtask

   task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] v);
      send_bits(DW'(a), AW);
      send_bit(1'b0, 1'b1);
      v = '0;
      for (int i = 0; i < DW; i++) begin
         ser_din = 1'b0;
         wt(HOLD);
         v = {v[DW-2:0], ser_dout};
         ser_clk = 1'b1; wt(HOLD);
         ser_clk = 1'b0; wt(HOLD);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      wt(5);
      check("R1 mode reset", mode_word, '0);
      check("R1 mux reset", mux_word, '0);
      check("R1 dout idle", DW'(ser_dout), 1);
      check("R1 req idle", DW'(reset_req), 0);
      rst_n = 1'b1;
      wt(4);
      do_read(8'hFF, v);                       // start-up read of the version
      check("R6 version read", v, VER);
      wt(HOLD);
      check("R4 dout high after read", DW'(ser_dout), 1);
      do_write(8'h00, 32'h1234_5678);
      wt(HOLD);
      check("R2 mode written", mode_word, 32'h1234_5678);
      check("R4 dout high after write", DW'(ser_dout), 1);
      do_write(8'h02, 32'hDEAD_BEEF);
      wt(HOLD);
      check("R2 mux written", mux_word, 32'hDEAD_BEEF);
      do_read(8'h00, v);
      check("R3 mode readback", v, 32'h1234_5678);
      do_read(8'h02, v);
      check("R3 mux readback", v, 32'hDEAD_BEEF);
      do_write(8'hFF, 32'h0BAD_0BAD);
      do_write(8'h08, 32'hFFFF_FFFF);
      do_write(8'h40, 32'h5555_AAAA);
      wt(HOLD);
      check("R5 mode kept", mode_word, 32'h1234_5678);
      check("R5 mux kept", mux_word, 32'hDEAD_BEEF);
      do_read(8'hFF, v);
      check("R5 version kept", v, VER);
      do_read(8'h08, v);
      check("R6 switch read", v, DW'(SWV));
      do_read(8'h40, v);
      check("R6 unmapped read zero", v, '0);
      req_hi = 0;
      do_write(8'h80, 32'h0000_0002);
      wt(20);
      check("R7 other value no pulse", DW'(req_hi), 0);
      do_write(8'h80, 32'h0000_0001);
      wt(20);
      check("R7 pulse length", DW'(req_hi), DW'(PULSE));
      do_read(8'h80, v);
      check("R7 reset entry cleared", v, '0);
      send_bits(32'hCAFE_F00D, DW);
      send_bits(32'h0000_0000, AW);
      wt(HOLD);
      check("R8 unstrobed clocks ignored", mode_word, 32'h1234_5678);
      send_bit(1'b1, 1'b1);
      wt(HOLD);
      check("R8 strobe commits history", mode_word, 32'hCAFE_F00D);
      wt(10);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule